// File: doc/BRIEF.md
# EEPROM Write-Enable and Protection Guard

This block holds the status state of a serial EEPROM: the write-enable latch, the busy flag and the nonvolatile protection fields. It sits beside the serial command decoder and the write sequencer. The decoder hands it one-cycle strobes. The block answers each write commit in the same cycle with an allow or a deny pulse. It also presents the full status byte at all times, so the byte can be shifted out whenever it is requested, including while a write cycle runs.

The enable latch is set in two steps. First comes the enable command, and then the chip select must rise. An array or status write commit that arrives before that rise finds the latch clear. Array protection covers the top of the address space in quarters. A status byte bit, together with an active-low write-protect pin, can lock the status register while array writes stay available. The nonvolatile fields are modelled as ordinary registers.

Top module: `eeprom_wr_guard`

## Requirements
- R1: After reset, `status_o` is 8'h00, and no allow or deny output is high while no commit strobe is present.
- R2: An enable strobe followed in a later cycle by a `cs_rise_i` strobe sets status bit 1 (latch) from the cycle after the `cs_rise_i` strobe.
- R3: A write commit (array or status) after an enable strobe with no `cs_rise_i` strobe in between is denied, and status bit 1 stays 0.
- R4: A disable strobe clears status bit 1 on the next cycle, whatever the protection fields or the write-protect pin hold.
- R5: The status byte is {lock-enable bit 7, 3'b000, protection field bits 3:2, latch bit 1, busy bit 0}. An allowed status write loads only bits 7 and 3:2 from `sr_data_i`.
- R6: Protection field 2'b00 guards nothing. 2'b01 guards 1800h–1FFFh, 2'b10 guards 1000h–1FFFh and 2'b11 guards 0000h–1FFFh. An array commit that touches a guarded address is denied, does not set busy, and leaves the latch set.
- R7: An array commit to unguarded addresses while the latch is set and busy is clear is allowed, and status bit 0 reads 1 from the next cycle.
- R8: A `wr_done_i` strobe clears both busy and the latch on the next cycle.
- R9: When bit 7 is 1 and `wp_n_i` is low, status writes are denied and the status byte is unchanged. Array commits are still allowed under the same conditions.
- R10: When bit 7 is 0, the level of `wp_n_i` has no effect on status writes.
- R11: While busy is 1, every array and status commit is denied.
- R12: For each commit strobe, exactly one of its allow and deny outputs is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wren_i | input | 1 | Enable command fully received (strobe) |
| cs_rise_i | input | 1 | Chip select rose (strobe) |
| wrdi_i | input | 1 | Disable command received (strobe) |
| sr_wr_i | input | 1 | Status write commit (strobe) |
| sr_data_i | input | 8 | Byte offered for the status write |
| arr_wr_i | input | 1 | Array write commit (strobe) |
| arr_lo_i | input | ADDR_W | Lowest address of the commit |
| arr_hi_i | input | ADDR_W | Highest address of the commit |
| wp_n_i | input | 1 | Write-protect pin, active low |
| wr_done_i | input | 1 | Internal write cycle finished (strobe) |
| status_o | output | 8 | Status byte |
| arr_allow_o | output | 1 | Array commit accepted |
| arr_deny_o | output | 1 | Array commit refused |
| sr_allow_o | output | 1 | Status commit accepted |
| sr_deny_o | output | 1 | Status commit refused |

## Verification
A corrupt latch or busy flag appears on `status_o` one cycle after the strobe that caused it. A wrong protection decision appears in the same cycle as the commit, as an allow where a deny was expected or the other way round. A protection field or lock bit that was loaded wrongly may stay hidden until a commit probes it. For that reason, every field value is probed on both sides of each quarter boundary. The lock pin is exercised with bit 7 both set and clear.

// File: rtl/eg_pkg.sv
package eg_pkg;
  localparam int STAT_W = 8;
  localparam logic [STAT_W-1:0] NV_MASK = 8'b1000_1100;
  localparam int BIT_LOCK = 7;
  localparam int BIT_FLD_HI = 3;
  localparam int BIT_FLD_LO = 2;
endpackage

// File: rtl/eg_enable_latch.sv
module eg_enable_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic wren_i,
  input  logic cs_rise_i,
  input  logic other_i,
  input  logic clear_i,
  output logic wel_o
);
  logic armed_q, armed_d, armed_en;
  logic wel_q, wel_d, wel_en;

  always_comb begin
    armed_en = wren_i | cs_rise_i | other_i;
    armed_d  = wren_i;
    wel_en   = clear_i | (armed_q & cs_rise_i & ~other_i);
    wel_d    = ~clear_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      wel_q   <= 1'b0;
    end else begin
      if (armed_en) armed_q <= armed_d;
      if (wel_en)   wel_q   <= wel_d;
    end
  end

  assign wel_o = wel_q;

  p_set_after_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(cs_rise_i));
  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !wel_q);
endmodule

// File: rtl/eg_region_check.sv
module eg_region_check #(
  parameter int ADDR_W = 13
) (
  input  logic [1:0]        fld_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  output logic              hit_o
);
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W:0] QTR  = SPAN >> 2;

  logic [ADDR_W:0] base;

  always_comb begin
    unique case (fld_i)
      2'b00:   base = SPAN;
      2'b01:   base = SPAN - QTR;
      2'b10:   base = SPAN - (QTR << 1);
      default: base = '0;
    endcase
    hit_o = ({1'b0, lo_i} >= base) | ({1'b0, hi_i} >= base);
  end
endmodule

// File: rtl/eg_nv_status.sv
module eg_nv_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] din_i,
  output logic [7:0] nv_o
);
  import eg_pkg::*;
  logic [7:0] nv_q, nv_d;

  always_comb nv_d = din_i & NV_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nv_q <= '0;
    else if (load_i) nv_q <= nv_d;
  end

  assign nv_o = nv_q;

  p_hold_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(nv_q));
endmodule

// File: rtl/eeprom_wr_guard.sv
module eeprom_wr_guard #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_i,
  input  logic              cs_rise_i,
  input  logic              wrdi_i,
  input  logic              sr_wr_i,
  input  logic [7:0]        sr_data_i,
  input  logic              arr_wr_i,
  input  logic [ADDR_W-1:0] arr_lo_i,
  input  logic [ADDR_W-1:0] arr_hi_i,
  input  logic              wp_n_i,
  input  logic              wr_done_i,
  output logic [7:0]        status_o,
  output logic              arr_allow_o,
  output logic              arr_deny_o,
  output logic              sr_allow_o,
  output logic              sr_deny_o
);
  import eg_pkg::*;

  logic       wel, hit, lock;
  logic [7:0] nv;
  logic       wip_q, wip_d, wip_en;
  logic       arr_ok, sr_ok;

  eg_enable_latch u_latch (
    .clk(clk), .rst_n(rst_n), .wren_i(wren_i), .cs_rise_i(cs_rise_i),
    .other_i(wrdi_i | sr_wr_i | arr_wr_i), .clear_i(wrdi_i | wr_done_i),
    .wel_o(wel)
  );

  eg_nv_status u_nv (
    .clk(clk), .rst_n(rst_n), .load_i(sr_allow_o), .din_i(sr_data_i), .nv_o(nv)
  );

  eg_region_check #(.ADDR_W(ADDR_W)) u_region (
    .fld_i(nv[BIT_FLD_HI:BIT_FLD_LO]), .lo_i(arr_lo_i), .hi_i(arr_hi_i),
    .hit_o(hit)
  );

  always_comb begin
    lock        = nv[BIT_LOCK] & ~wp_n_i;
    arr_ok      = wel & ~wip_q & ~hit;
    sr_ok       = wel & ~wip_q & ~lock;
    arr_allow_o = arr_wr_i & arr_ok;
    arr_deny_o  = arr_wr_i & ~arr_ok;
    sr_allow_o  = sr_wr_i & sr_ok;
    sr_deny_o   = sr_wr_i & ~sr_ok;
    wip_en      = wr_done_i | arr_allow_o | sr_allow_o;
    wip_d       = ~wr_done_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wip_q <= 1'b0;
    else if (wip_en) wip_q <= wip_d;
  end

  assign status_o = nv | {6'b0, wel, wip_q};

  p_grant_needs_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_allow_o | sr_allow_o) |-> (status_o[1] && !status_o[0]));
  p_grant_sets_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_allow_o | sr_allow_o) |=> status_o[0]);
  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done_i |=> (status_o[1:0] == 2'b00));
  p_lock_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_i && status_o[7] && !wp_n_i) |-> sr_deny_o);
  p_busy_refuses_r11: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] |-> !(arr_allow_o || sr_allow_o));
  p_one_answer_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_allow_o, arr_deny_o}) && $onehot0({sr_allow_o, sr_deny_o}));
endmodule

// File: tb/eeprom_wr_guard_test.sv
module eeprom_wr_guard_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wren_i = 0, cs_rise_i = 0, wrdi_i = 0, sr_wr_i = 0, arr_wr_i = 0;
  logic wr_done_i = 0, wp_n_i = 1;
  logic [7:0] sr_data_i = 0;
  logic [12:0] arr_lo_i = 0, arr_hi_i = 0;
  logic [7:0] status_o;
  logic arr_allow_o, arr_deny_o, sr_allow_o, sr_deny_o;
  int n_chk = 0, n_bad = 0;
  logic got_aa, got_ad, got_sa, got_sd;

  always #4 clk = ~clk;

  eeprom_wr_guard uut (.*);

  localparam logic [5:0] K_WREN = 6'd1, K_CS = 6'd2, K_WRDI = 6'd4,
                         K_SR = 6'd8, K_ARR = 6'd16, K_DONE = 6'd32;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [5:0] k, input logic [7:0] d, input logic [12:0] lo,
                       input logic [12:0] hi);
    wren_i = k[0]; cs_rise_i = k[1]; wrdi_i = k[2]; sr_wr_i = k[3];
    arr_wr_i = k[4]; wr_done_i = k[5]; sr_data_i = d; arr_lo_i = lo; arr_hi_i = hi;
    #1;
    got_aa = arr_allow_o; got_ad = arr_deny_o; got_sa = sr_allow_o; got_sd = sr_deny_o;
    @(negedge clk);
    wren_i = 0; cs_rise_i = 0; wrdi_i = 0; sr_wr_i = 0; arr_wr_i = 0; wr_done_i = 0;
  endtask

  task automatic enable();
    pulse(K_WREN, 0, 0, 0);
    pulse(K_CS, 0, 0, 0);
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 8'h00);
    chk("R1 idle outputs", {arr_allow_o, arr_deny_o, sr_allow_o, sr_deny_o}, 4'b0000);
  endtask

  task automatic t_no_cs();
    pulse(K_WREN, 0, 0, 0);
    pulse(K_ARR, 0, 13'h0010, 13'h0010);
    chk("R3 array deny", {got_aa, got_ad}, 2'b01);
    chk("R3 latch clear", status_o, 8'h00);
    pulse(K_WREN, 0, 0, 0);
    pulse(K_SR, 8'h0C, 0, 0);
    chk("R3 status deny", {got_sa, got_sd}, 2'b01);
    chk("R3 status kept", status_o, 8'h00);
  endtask

  task automatic t_array_write();
    enable();
    chk("R2 latch set", status_o, 8'h02);
    pulse(K_ARR, 0, 13'h0100, 13'h011F);
    chk("R7 allow", {got_aa, got_ad}, 2'b10);
    chk("R7 busy", status_o, 8'h03);
    pulse(K_SR, 8'h8C, 0, 0);
    chk("R11 status deny busy", {got_sa, got_sd}, 2'b01);
    pulse(K_ARR, 0, 13'h0000, 13'h0000);
    chk("R11 array deny busy", {got_aa, got_ad}, 2'b01);
    chk("R12 one answer", {got_aa, got_ad, got_sa, got_sd}, 4'b0100);
    pulse(K_DONE, 0, 0, 0);
    chk("R8 done clears", status_o, 8'h00);
  endtask

  task automatic t_status_write();
    enable();
    pulse(K_SR, 8'hFF, 0, 0);
    chk("R5 allow", {got_sa, got_sd}, 2'b10);
    chk("R5 layout", status_o, 8'h8F);
    pulse(K_DONE, 0, 0, 0);
    chk("R5 after done", status_o, 8'h8C);
    enable();
    pulse(K_SR, 8'h00, 0, 0);
    pulse(K_DONE, 0, 0, 0);
    chk("R5 cleared", status_o, 8'h00);
  endtask

  task automatic t_protect();
    logic [12:0] probes [5] = '{13'h0000, 13'h0FFF, 13'h1000, 13'h17FF, 13'h1800};
    for (int f = 0; f < 4; f++) begin
      int base;
      base = (f == 0) ? 8192 : (f == 1) ? 6144 : (f == 2) ? 4096 : 0;
      enable();
      pulse(K_SR, {4'b0, 2'(f), 2'b00}, 0, 0);
      pulse(K_DONE, 0, 0, 0);
      for (int p = 0; p < 5; p++) begin
        logic deny;
        deny = (int'(probes[p]) >= base);
        enable();
        pulse(K_ARR, 0, probes[p], probes[p]);
        chk($sformatf("R6 fld=%0d addr=%h", f, probes[p]), {got_aa, got_ad}, {~deny, deny});
        if (deny) begin
          chk("R6 latch kept, not busy", status_o[1:0], 2'b10);
          pulse(K_WRDI, 0, 0, 0);
        end else pulse(K_DONE, 0, 0, 0);
      end
    end
    enable();
    pulse(K_ARR, 0, 13'h1000, 13'h1800);
    chk("R6 range end guarded", {got_aa, got_ad}, 2'b01);
    pulse(K_WRDI, 0, 0, 0);
    chk("R4 disable", status_o[1:0], 2'b00);
    enable();
    pulse(K_SR, 8'h00, 0, 0);
    pulse(K_DONE, 0, 0, 0);
  endtask

  task automatic t_lock();
    enable();
    pulse(K_SR, 8'h80, 0, 0);
    pulse(K_DONE, 0, 0, 0);
    wp_n_i = 0;
    enable();
    pulse(K_SR, 8'h0C, 0, 0);
    chk("R9 status locked", {got_sa, got_sd}, 2'b01);
    chk("R9 status unchanged", status_o, 8'h82);
    pulse(K_ARR, 0, 13'h1FFF, 13'h1FFF);
    chk("R9 array still open", {got_aa, got_ad}, 2'b10);
    pulse(K_DONE, 0, 0, 0);
    enable();
    pulse(K_WRDI, 0, 0, 0);
    chk("R4 disable under lock", status_o, 8'h80);
    wp_n_i = 1;
    enable();
    pulse(K_SR, 8'h00, 0, 0);
    chk("R9 pin high opens", {got_sa, got_sd}, 2'b10);
    pulse(K_DONE, 0, 0, 0);
    wp_n_i = 0;
    enable();
    pulse(K_SR, 8'h04, 0, 0);
    chk("R10 pin ignored", {got_sa, got_sd}, 2'b10);
    pulse(K_DONE, 0, 0, 0);
    chk("R10 field loaded", status_o, 8'h04);
    wp_n_i = 1;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_no_cs();
    t_array_write();
    t_status_write();
    t_protect();
    t_lock();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule